// File: doc/BRIEF.md
# I2C Master Stop-Condition Controller

This block is the part of an I2C master that clocks bytes, parks the bus in a wait, and ends a transfer with a stop condition. Software-style single-cycle strobes ask it to start, to stop, to release a wait, or to drop the bus. Level inputs choose the wait point, the transfer direction and whether the receiver acknowledges. SCL and SDA are driven through open-drain enables, where a 1 pulls the line low. Both lines are read back through a two-flop synchronizer.

A stop request is checked against the current mode and bus phase. An illegal request gives a one-cycle error pulse. A legal one is held pending until the stop appears on the bus or an abort removes it. The stop sequence pulls SDA low while SCL is low, then releases SCL and waits until SCL reads high. It then holds for a programmed number of cycles and releases SDA, so that SDA rises while SCL is high. The stop bit reads back as zero at all times.

States: `ST_IDLE` (bus released, not master), `ST_START` (SDA low with SCL high), `ST_LOW` / `ST_HIGH` (the two halves of a bus clock), `ST_WAIT` (SCL held low), `ST_STOP_A` (SDA low, SCL low), `ST_STOP_B` (SCL released, waiting for it to read high), `ST_STOP_C` (hold time with SCL high), `ST_STOP_D` (SDA released, waiting for the stop to be seen). Transitions:
- IDLE→START on a start strobe while the bus is free.
- START→LOW and LOW→HIGH when the half-period timer expires.
- HIGH→LOW after a clock, or HIGH→WAIT when the wait point is reached.
- HIGH→IDLE on arbitration loss.
- WAIT→LOW on a wait release.
- WAIT→STOP_A when a stop is pending at the 9th-clock wait.
- STOP_A→STOP_B on the timer.
- STOP_B→STOP_C once SCL reads high.
- STOP_C→STOP_D on the timer.
- STOP_D→IDLE once the stop is detected.
- Any state→IDLE when the block is disabled or the communication-release strobe is given.

Top module: `i2c_stop_ctrl`

## Requirements
- R1: A stop request made while the block is not master (`master`=0) is ignored: `stop_pend` stays 0 and `stop_err` stays 0.
- R2: A stop request given in the same cycle as a start request is rejected: `stop_pend` does not rise and `stop_err` pulses.
- R3: `stop_rd`, the read-back of the stop trigger, is 0 at all times, including the cycle right after a stop request is accepted.
- R4: The stop sequence releases SCL while SDA is held low. SDA is released no sooner than HALF_CYC clock cycles after SCL is seen high, so that SDA rises while SCL is high. The block then leaves master mode.
- R5: A pending stop is cleared by any of these: a stop detected on the bus, the `comm_rel` strobe, `en`=0, arbitration loss, or reset.
- R6: A stop request is accepted only in the wait that follows the 9th clock. A request made in the wait after the 8th clock, or while clocks are running, pulses `stop_err` and is not held.
- R7: When receiving (`tx_flag`=0), a stop request is accepted only if `ack_en`=0, and otherwise pulses `stop_err`. With `ack_en`=1, the receiver pulls SDA low during the 9th clock.
- R8: A stop request made while one is already pending pulses `stop_err`.
- R9: With `wait_sel9`=0, the block holds SCL low (`waiting`=1) after the 8th SCL rising edge of a byte. With `wait_sel9`=1, it does so after the 9th. `wait_sel9` is sampled live, so it can be changed during the 8th-clock wait.
- R10: `tx_flag` loads from `dir_tx` at start and again at each wait release of the 9th-clock wait. While transmitting, SDA is left released during the 9th clock.
- R11: If SDA reads low during the high phase of clocks 1 to 8, while the block is not pulling it, `arb_lost` pulses. The block releases both lines and leaves master mode.
- R12: `stop_err` is a single-cycle pulse for each rejected request.
- R13: A start strobe in idle with the bus free pulls SDA low while SCL stays released, and sets `master`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Block enable; 0 aborts to idle |
| start_req | input | 1 | Start trigger strobe |
| stop_req | input | 1 | Stop trigger strobe |
| wait_sel9 | input | 1 | Wait point: 0 after 8th clock, 1 after 9th |
| ack_en | input | 1 | Receiver acknowledge enable |
| dir_tx | input | 1 | Direction for the next load of the transmit flag (1 = transmit) |
| wait_rel | input | 1 | Wait release strobe |
| comm_rel | input | 1 | Communication release strobe |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| master | output | 1 | Block is bus master |
| waiting | output | 1 | SCL is held in a wait |
| tx_flag | output | 1 | Transmit flag |
| stop_pend | output | 1 | Stop request pending |
| stop_rd | output | 1 | Stop trigger read-back (always 0) |
| stop_err | output | 1 | One-cycle pulse on a rejected stop request |
| arb_lost | output | 1 | One-cycle pulse on arbitration loss |

## Verification
Stop requests are made in several situations: while idle, together with a start, at the 8th-clock wait, at the 9th-clock wait as transmitter and as receiver with and without acknowledge, and again while one is pending. This separates the mode gate from the wait-point gate, the acknowledge gate and the duplicate gate. Pending stops are ended three ways: by the completed bus stop, by a communication release, and by disabling the block. Each path must clear the pending flag and master mode on its own. A forced low on SDA during data clocks checks the arbitration abort. Edges sampled on the modelled bus check the order of SCL and SDA in the stop and the hold time before SDA rises.

// File: rtl/i2c_stop_pkg.sv
package i2c_stop_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_LOW,
        ST_HIGH,
        ST_WAIT,
        ST_STOP_A,
        ST_STOP_B,
        ST_STOP_C,
        ST_STOP_D
    } mst_state_e;

    localparam int unsigned BITS_PER_BYTE = 8;
    localparam int unsigned CLKS_PER_BYTE = BITS_PER_BYTE + 1;
endpackage

// File: rtl/i2c_sync.sv
module i2c_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic m1;
        logic m2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                m1 <= 1'b1;
                m2 <= 1'b1;
            end else begin
                m1 <= d[i];
                m2 <= m1;
            end
        end
        assign q[i] = m2;
    end
endmodule

// File: rtl/i2c_bus_mon.sv
module i2c_bus_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic stop_seen
);
    logic scl_d;
    logic sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // SDA rising while SCL high on both samples
    assign stop_seen = scl_s && scl_d && sda_s && !sda_d;
endmodule

// File: rtl/i2c_stop_gate.sv
module i2c_stop_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_wr,
    input  logic start_wr,
    input  logic master,
    input  logic at_wait9,
    input  logic tx_flag,
    input  logic ack_en,
    input  logic cancel,
    output logic pend,
    output logic err
);
    logic conflict;
    logic legal;
    logic accept;
    logic reject;

    always_comb begin
        conflict = stop_wr && start_wr;
        legal    = !pend && at_wait9 && (tx_flag || !ack_en);
        accept   = stop_wr && master && !conflict && legal;
        reject   = conflict || (stop_wr && master && !legal);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 1'b0;
            err  <= 1'b0;
        end else begin
            err <= reject;
            if (cancel)
                pend <= 1'b0;
            else if (accept)
                pend <= 1'b1;
        end
    end

    AST_PEND_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !$past(pend)) |-> $past(master)); // R1
    AST_START_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_wr && start_wr && !pend) |=> (err && !pend)); // R2
    AST_DOUBLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_wr && pend && master) |=> err); // R8
    AST_CANCEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |=> !pend); // R5
endmodule

// File: rtl/i2c_stop_ctrl.sv
module i2c_stop_ctrl #(
    parameter int HALF_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic start_req,
    input  logic stop_req,
    input  logic wait_sel9,
    input  logic ack_en,
    input  logic dir_tx,
    input  logic wait_rel,
    input  logic comm_rel,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_oe,
    output logic sda_oe,
    output logic master,
    output logic waiting,
    output logic tx_flag,
    output logic stop_pend,
    output logic stop_rd,
    output logic stop_err,
    output logic arb_lost
);
    import i2c_stop_pkg::*;

    localparam int TW = $clog2(HALF_CYC + 1);
    localparam int CW = $clog2(CLKS_PER_BYTE + 1);
    localparam logic [CW-1:0] LAST_DATA = CW'(BITS_PER_BYTE);
    localparam logic [CW-1:0] LAST_CLK  = CW'(CLKS_PER_BYTE);

    mst_state_e    state, state_n;
    logic [TW-1:0] timer, timer_n;
    logic [CW-1:0] bit_cnt, cnt_n, cnt_inc;
    logic          tx_q, tx_n;
    logic          arb_q, arb_n;
    logic [1:0]    bus_s;
    logic          scl_s, sda_s;
    logic          stop_seen;
    logic          tmr_done, wait_hit, at_wait9, cancel;

    i2c_sync #(.W(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({scl_in, sda_in}),
        .q    (bus_s)
    );
    assign scl_s = bus_s[1];
    assign sda_s = bus_s[0];

    i2c_bus_mon u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .stop_seen(stop_seen)
    );

    assign at_wait9 = (state == ST_WAIT) && (bit_cnt == LAST_CLK);
    assign cancel   = arb_q || stop_seen || comm_rel || !en;

    i2c_stop_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .stop_wr (stop_req),
        .start_wr(start_req),
        .master  (master),
        .at_wait9(at_wait9),
        .tx_flag (tx_q),
        .ack_en  (ack_en),
        .cancel  (cancel),
        .pend    (stop_pend),
        .err     (stop_err)
    );

    assign tmr_done = (timer == TW'(HALF_CYC - 1));
    assign cnt_inc  = bit_cnt + 1'b1;
    assign wait_hit = ((cnt_inc == LAST_DATA) && !wait_sel9) ||
                      ((cnt_inc == LAST_CLK)  &&  wait_sel9);

    // next-state logic
    always_comb begin
        state_n = state;
        timer_n = timer + 1'b1;
        cnt_n   = bit_cnt;
        tx_n    = tx_q;
        arb_n   = 1'b0;
        if (!en || comm_rel) begin
            state_n = ST_IDLE;
            timer_n = '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    timer_n = '0;
                    if (start_req && scl_s && sda_s) begin
                        state_n = ST_START;
                        cnt_n   = '0;
                        tx_n    = dir_tx;
                    end
                end
                ST_START, ST_LOW, ST_STOP_A, ST_STOP_C: begin
                    if (tmr_done) begin
                        timer_n = '0;
                        unique case (state)
                            ST_START:  state_n = ST_LOW;
                            ST_LOW:    state_n = ST_HIGH;
                            ST_STOP_A: state_n = ST_STOP_B;
                            default:   state_n = ST_STOP_D;
                        endcase
                    end
                end
                ST_HIGH: begin
                    if (!scl_s) begin
                        timer_n = '0;
                    end else if (!sda_s && !sda_oe && (bit_cnt < LAST_DATA)) begin
                        state_n = ST_IDLE;
                        timer_n = '0;
                        arb_n   = 1'b1;
                    end else if (tmr_done) begin
                        timer_n = '0;
                        if (wait_hit) begin
                            state_n = ST_WAIT;
                            cnt_n   = cnt_inc;
                        end else begin
                            state_n = ST_LOW;
                            cnt_n   = (cnt_inc == LAST_CLK) ? '0 : cnt_inc;
                        end
                    end
                end
                ST_WAIT: begin
                    timer_n = '0;
                    if (stop_pend && at_wait9) begin
                        state_n = ST_STOP_A;
                    end else if (wait_rel) begin
                        state_n = ST_LOW;
                        if (bit_cnt == LAST_CLK) begin
                            cnt_n = '0;
                            tx_n  = dir_tx;
                        end
                    end
                end
                ST_STOP_B: begin
                    timer_n = '0;
                    if (scl_s)
                        state_n = ST_STOP_C;
                end
                ST_STOP_D: begin
                    timer_n = '0;
                    if (stop_seen)
                        state_n = ST_IDLE;
                end
                default: begin
                    state_n = ST_IDLE;
                    timer_n = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            timer   <= '0;
            bit_cnt <= '0;
            tx_q    <= 1'b0;
            arb_q   <= 1'b0;
        end else begin
            state   <= state_n;
            timer   <= timer_n;
            bit_cnt <= cnt_n;
            tx_q    <= tx_n;
            arb_q   <= arb_n;
        end
    end

    // outputs
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (state)
            ST_START: sda_oe = 1'b1;
            ST_LOW, ST_HIGH: begin
                scl_oe = (state == ST_LOW);
                sda_oe = (bit_cnt == LAST_DATA) && !tx_q && ack_en;
            end
            ST_WAIT:   scl_oe = 1'b1;
            ST_STOP_A: begin
                scl_oe = 1'b1;
                sda_oe = 1'b1;
            end
            ST_STOP_B, ST_STOP_C: sda_oe = 1'b1;
            default: begin
                scl_oe = 1'b0;
                sda_oe = 1'b0;
            end
        endcase
    end

    assign master   = (state != ST_IDLE);
    assign waiting  = (state == ST_WAIT);
    assign tx_flag  = tx_q;
    assign stop_rd  = 1'b0;
    assign arb_lost = arb_q;

    AST_SDA_RISES_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP_D && $past(state) == ST_STOP_C) |-> scl_s); // R4
    AST_STOP_FROM_WAIT9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP_A && $past(state) == ST_WAIT) |-> ($past(bit_cnt) == LAST_CLK)); // R6
    AST_ARB_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> (!master && !scl_oe && !sda_oe)); // R11
    AST_STOP_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP_A && $past(state) == ST_WAIT) |-> $past(stop_pend)); // R5
endmodule

// File: tb/i2c_stop_ctrl_tb.sv
module i2c_stop_ctrl_tb;
    localparam int HC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, start_req = 1'b0, stop_req = 1'b0, wait_sel9 = 1'b1;
    logic ack_en = 1'b0, dir_tx = 1'b1, wait_rel = 1'b0, comm_rel = 1'b0;
    logic ext_sda_lo = 1'b0;
    logic scl_oe, sda_oe, master, waiting, tx_flag, stop_pend, stop_rd, stop_err, arb_lost;
    logic scl_line, sda_line;

    int n_chk = 0, n_fail = 0;
    int cyc = 0, rise_cnt = 0, rise_cyc = 0, stop_cnt = 0, stop_cyc = 0;
    logic scl_p = 1'b1, sda_p = 1'b1, sda_at_rise = 1'b1, arb_seen = 1'b0, clr_mon = 1'b0;

    always #5 clk = ~clk;

    assign scl_line = !scl_oe;
    assign sda_line = !(sda_oe || ext_sda_lo);

    i2c_stop_ctrl #(.HALF_CYC(HC)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .start_req(start_req), .stop_req(stop_req),
        .wait_sel9(wait_sel9), .ack_en(ack_en), .dir_tx(dir_tx), .wait_rel(wait_rel),
        .comm_rel(comm_rel), .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe),
        .sda_oe(sda_oe), .master(master), .waiting(waiting), .tx_flag(tx_flag),
        .stop_pend(stop_pend), .stop_rd(stop_rd), .stop_err(stop_err), .arb_lost(arb_lost)
    );

    always @(posedge clk) begin
        cyc   <= cyc + 1;
        scl_p <= scl_line;
        sda_p <= sda_line;
        if (clr_mon) begin
            rise_cnt <= 0;
            arb_seen <= 1'b0;
        end else begin
            if (!scl_p && scl_line) begin
                rise_cnt    <= rise_cnt + 1;
                rise_cyc    <= cyc;
                sda_at_rise <= sda_line;
            end
            if (arb_lost) arb_seen <= 1'b1;
        end
        if (scl_p && scl_line && !sda_p && sda_line) begin
            stop_cnt <= stop_cnt + 1;
            stop_cyc <= cyc;
        end
    end

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) if (cyc > 150000) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        report();
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(negedge clk) clr_mon = 1'b1;
        @(negedge clk) clr_mon = 1'b0;
    endtask

    task automatic stop_write(input logic with_start, output logic e, output logic p);
        @(negedge clk);
        stop_req = 1'b1;
        start_req = with_start;
        @(negedge clk);
        stop_req = 1'b0;
        start_req = 1'b0;
        e = stop_err;
        p = stop_pend;
    endtask

    task automatic strobe_start();
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
    endtask

    task automatic strobe_wait_rel();
        @(negedge clk) wait_rel = 1'b1;
        @(negedge clk) wait_rel = 1'b0;
    endtask

    task automatic wait_for_wait(input string req);
        int n = 0;
        while (!waiting && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(req, int'(waiting), 1);
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (master && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(req, int'(master), 0);
    endtask

    task automatic t_reset();
        chk("R3 reset stop_rd", int'(stop_rd), 0);
        chk("R1 reset idle", int'({scl_oe, sda_oe, master, stop_pend, stop_err}), 0);
    endtask

    task automatic t_idle_stop();
        logic e, p;
        stop_write(1'b0, e, p);
        chk("R1 idle stop err", int'(e), 0);
        chk("R1 idle stop pend", int'(p), 0);
    endtask

    task automatic t_tx_stop();
        logic e, p;
        int stops0;
        wait_sel9 = 1'b0;
        dir_tx = 1'b1;
        clear_mon();
        strobe_start();
        chk("R13 start master", int'(master), 1);
        chk("R13 start SDA low SCL high", int'({sda_oe, scl_oe}), 2);
        wait_for_wait("R9 wait8 reached");
        chk("R9 wait8 edges", rise_cnt, 8);
        chk("R9 wait8 SCL held", int'(scl_oe), 1);
        stop_write(1'b0, e, p);
        chk("R6 stop at wait8 err", int'(e), 1);
        chk("R6 stop at wait8 pend", int'(p), 0);
        @(negedge clk);
        chk("R12 err single cycle", int'(stop_err), 0);
        wait_sel9 = 1'b1;
        strobe_wait_rel();
        stop_write(1'b0, e, p);
        chk("R6 stop while clocking err", int'(e), 1);
        wait_for_wait("R9 wait9 reached");
        chk("R9 wait9 edges", rise_cnt, 9);
        chk("R10 tx ack slot released", int'(sda_at_rise), 1);
        stop_write(1'b1, e, p);
        chk("R2 stop with start err", int'(e), 1);
        chk("R2 stop with start pend", int'(p), 0);
        stops0 = stop_cnt;
        stop_write(1'b0, e, p);
        chk("R6 stop at wait9 err", int'(e), 0);
        chk("R6 stop at wait9 pend", int'(p), 1);
        chk("R3 read back after write", int'(stop_rd), 0);
        stop_write(1'b0, e, p);
        chk("R8 second stop err", int'(e), 1);
        wait_idle("R4 master drops after stop");
        chk("R4 one stop on bus", stop_cnt - stops0, 1);
        chk("R4 SDA low at SCL rise", int'(sda_at_rise), 0);
        chk("R4 hold before SDA rise", int'((stop_cyc - rise_cyc) >= HC), 1);
        chk("R5 stop seen clears pend", int'(stop_pend), 0);
    endtask

    task automatic t_rx_stop();
        logic e, p;
        dir_tx = 1'b0;
        ack_en = 1'b1;
        wait_sel9 = 1'b1;
        clear_mon();
        strobe_start();
        wait_for_wait("R9 rx wait9");
        chk("R7 receiver tx_flag", int'(tx_flag), 0);
        chk("R7 receiver acks low", int'(sda_at_rise), 0);
        stop_write(1'b0, e, p);
        chk("R7 stop with ack_en err", int'(e), 1);
        chk("R7 stop with ack_en pend", int'(p), 0);
        ack_en = 1'b0;
        stop_write(1'b0, e, p);
        chk("R7 stop without ack accepted", int'(p), 1);
        @(negedge clk) comm_rel = 1'b1;
        @(negedge clk) comm_rel = 1'b0;
        chk("R5 comm_rel clears pend", int'(stop_pend), 0);
        chk("R5 comm_rel leaves master", int'(master), 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_dir_and_disable();
        logic e, p;
        dir_tx = 1'b1;
        ack_en = 1'b0;
        clear_mon();
        strobe_start();
        wait_for_wait("R10 first wait9");
        chk("R10 tx_flag loaded at start", int'(tx_flag), 1);
        dir_tx = 1'b0;
        strobe_wait_rel();
        chk("R10 tx_flag reloaded", int'(tx_flag), 0);
        @(negedge clk) wait_rel = 1'b0;
        while (waiting) @(negedge clk);
        wait_for_wait("R10 second wait9");
        stop_write(1'b0, e, p);
        chk("R5 pend before disable", int'(p), 1);
        @(negedge clk) en = 1'b0;
        @(negedge clk);
        chk("R5 disable clears pend", int'(stop_pend), 0);
        chk("R5 disable leaves master", int'(master), 0);
        en = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_arb();
        logic e, p;
        int n = 0;
        dir_tx = 1'b1;
        clear_mon();
        strobe_start();
        while (rise_cnt < 2 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        ext_sda_lo = 1'b1;
        n = 0;
        while (!arb_seen && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk("R11 arb_lost pulse", int'(arb_seen), 1);
        chk("R11 master dropped", int'(master), 0);
        chk("R11 lines released", int'({scl_oe, sda_oe}), 0);
        ext_sda_lo = 1'b0;
        repeat (4) @(negedge clk);
        stop_write(1'b0, e, p);
        chk("R1 stop after arb ignored", int'({e, p}), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        en = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_idle_stop();
        t_tx_stop();
        t_rx_stop();
        t_dir_and_disable();
        t_arb();
        report();
    end
endmodule